// File: doc/BRIEF.md
# ESF CRC-6 Generator and Checker

This block computes the 6-bit cyclic check over every 24-frame extended superframe of a serial T1 bitstream, with one path for transmit and one for receive. Each path follows its own bit-accept strobe and its own multiframe-start marker. From these it keeps track of where each bit falls within the 193-bit frame and within the 24-frame multiframe. The framing bit is bit 0 of each frame. It is a check bit in frames 2, 6, 10, 14, 18 and 22, a framing-pattern bit in frames 4, 8, 12, 16, 20 and 24, and a data-link bit in the odd frames. Frame numbers in this document are 1-based.

The transmit path gives the check value of the multiframe just completed. Framing logic downstream inserts it into the next multiframe. A force-error control inverts that value so that the line carries bad check bits. The receive path collects the check bits that arrive in a multiframe and compares them with the value it computed over the previous multiframe. On a mismatch it raises a one-cycle pulse.

A mode input selects T1 or J1 coverage. In T1 mode every framing-bit position enters the calculation as a 1. In J1 mode the pattern positions enter with their real line values.

Top module: `esf_crc6_unit`

## Requirements
- R1: The check uses the generator x^6 + x + 1 and is shifted MSB-first over the 4632 bits of one multiframe. The register starts from zero at the first bit of each multiframe. In the cycle after the last bit of a multiframe is accepted, tx_crc_o takes the remainder of that multiframe times x^6 modulo the generator. Otherwise tx_crc_o holds its value.
- R2: With j1_mode_i low, every framing-bit position (bit 0 of every frame) is taken as 1, whatever value is on the line.
- R3: With j1_mode_i high, the pattern positions (bit 0 of frames 4, 8, 12, 16, 20, 24) are taken at their line value. The check and data-link positions are still taken as 1.
- R4: If force_err_i is high when the last bit of a multiframe is accepted, tx_crc_o takes the bitwise inverse of the correct value.
- R5: The receive path reads the check bits from bit 0 of frames 2, 6, 10, 14, 18 and 22. Frame 2 carries bit 5, the MSB, and frame 22 carries bit 0.
- R6: rx_err_o is high for exactly one cycle, the cycle after the last bit of a multiframe is accepted, when the received check bits differ from the value computed over the previous multiframe. It is low in every other cycle.
- R7: No comparison is made for the first complete multiframe after reset or after a realignment. A realignment is a start marker accepted on a bit that is not the expected first bit. Before the first start marker has been accepted, tx_crc_o does not change.
- R8: A cycle with the bit-accept strobe low changes nothing, including when the start marker or the data input is high in that cycle.
- R9: After reset, tx_crc_o is 0 and rx_err_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| j1_mode_i | input | 1 | 0: T1 coverage, 1: J1 coverage |
| force_err_i | input | 1 | Invert the transmitted check value |
| tx_bit_en_i | input | 1 | Transmit bit accepted this cycle |
| tx_mf_start_i | input | 1 | Transmit bit is the first bit of a multiframe |
| tx_data_i | input | 1 | Transmit serial bit |
| tx_crc_o | output | 6 | Check value for insertion into the next multiframe |
| rx_bit_en_i | input | 1 | Receive bit accepted this cycle |
| rx_mf_start_i | input | 1 | Receive bit is the first bit of a multiframe |
| rx_data_i | input | 1 | Receive serial bit |
| rx_err_o | output | 1 | One-cycle pulse: received check mismatch |

## Verification
The transmit update, with or without inversion, and the receive comparison happen on the same edge whenever both streams end a multiframe together. The bench ties the two streams to one stimulus so that they always coincide. It then sweeps both modes, forced inversion on and off, and correct versus single-bit-corrupted check bits, moving the corrupted bit from one check slot to the next. At the falling edge after the last bit, tx_crc_o is compared against a long-division model and rx_err_o against the expected mismatch. The bench also counts any pulse that appears elsewhere in the multiframe.

// File: rtl/esf_crc6_pkg.sv
package esf_crc6_pkg;
  localparam int CRC_W = 6;
  localparam logic [CRC_W-1:0] CRC_POLY = 6'b000011; // x^6 + x + 1, x^6 implicit

  typedef enum logic [1:0] {
    SLOT_DATA = 2'd0,
    SLOT_DL   = 2'd1,
    SLOT_CRC  = 2'd2,
    SLOT_FE   = 2'd3
  } slot_e;

  function automatic logic [CRC_W-1:0] crc6_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & CRC_POLY);
  endfunction
endpackage

// File: rtl/esf_pos_tracker.sv
module esf_pos_tracker
  import esf_crc6_pkg::*;
#(
  parameter int FRAME_BITS = 193,
  parameter int FRAMES     = 24,
  localparam int BIT_W = $clog2(FRAME_BITS),
  localparam int FRM_W = $clog2(FRAMES),
  localparam int IDX_W = FRM_W - 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             mf_start_i,
  output slot_e            slot_o,
  output logic [IDX_W-1:0] crc_idx_o,
  output logic             first_o,
  output logic             last_o,
  output logic             slip_o
);
  logic [BIT_W-1:0] bit_q, cur_bit;
  logic [FRM_W-1:0] frame_q, cur_frame;
  logic             locked_q;
  logic             end_of_frame, end_of_mf;

  always_comb begin
    cur_bit      = mf_start_i ? '0 : bit_q;
    cur_frame    = mf_start_i ? '0 : frame_q;
    end_of_frame = (cur_bit == BIT_W'(FRAME_BITS - 1));
    end_of_mf    = end_of_frame && (cur_frame == FRM_W'(FRAMES - 1));
    first_o      = bit_en_i & mf_start_i;
    last_o       = bit_en_i & (locked_q | mf_start_i) & end_of_mf;
    // start marker off the expected first bit while aligned
    slip_o       = bit_en_i & mf_start_i & locked_q & ((bit_q != '0) | (frame_q != '0));
    crc_idx_o    = cur_frame[FRM_W-1:2];
    if (cur_bit != '0) begin
      slot_o = SLOT_DATA;
    end else begin
      unique case (cur_frame[1:0])
        2'd1:    slot_o = SLOT_CRC;
        2'd3:    slot_o = SLOT_FE;
        default: slot_o = SLOT_DL;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q    <= '0;
      frame_q  <= '0;
      locked_q <= 1'b0;
    end else if (bit_en_i) begin
      locked_q <= locked_q | mf_start_i;
      if (end_of_frame) begin
        bit_q   <= '0;
        frame_q <= end_of_mf ? '0 : cur_frame + 1'b1;
      end else begin
        bit_q   <= cur_bit + 1'b1;
        frame_q <= cur_frame;
      end
    end
  end
endmodule

// File: rtl/esf_crc6_engine.sv
module esf_crc6_engine
  import esf_crc6_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             first_i,
  input  logic             last_i,
  input  slot_e            slot_i,
  input  logic             data_i,
  input  logic             j1_mode_i,
  output logic             done_o,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q, seed, nxt;
  logic             eff_bit;

  always_comb begin
    unique case (slot_i)
      SLOT_DATA: eff_bit = data_i;
      SLOT_FE:   eff_bit = j1_mode_i ? data_i : 1'b1;
      default:   eff_bit = 1'b1;
    endcase
    seed   = first_i ? '0 : crc_q;
    nxt    = crc6_step(seed, eff_bit);
    done_o = bit_en_i & last_i;
    crc_o  = nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       crc_q <= '0;
    else if (bit_en_i) crc_q <= nxt;
  end
endmodule

// File: rtl/esf_crc_rx_cmp.sv
module esf_crc_rx_cmp
  import esf_crc6_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  slot_e            slot_i,
  input  logic [IDX_W-1:0] crc_idx_i,
  input  logic             data_i,
  input  logic             slip_i,
  input  logic             done_i,
  input  logic [CRC_W-1:0] calc_i,
  output logic             err_o
);
  logic [CRC_W-1:0] got_q, prev_q, sel;
  logic             prev_ok_q, err_q;

  always_comb begin
    for (int k = 0; k < CRC_W; k++) begin
      sel[CRC_W-1-k] = bit_en_i && (slot_i == SLOT_CRC) && (crc_idx_i == IDX_W'(k));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      got_q     <= '0;
      prev_q    <= '0;
      prev_ok_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      for (int k = 0; k < CRC_W; k++) begin
        if (sel[k]) got_q[k] <= data_i;
      end
      err_q <= done_i && prev_ok_q && (got_q != prev_q);
      if (done_i) begin
        prev_q    <= calc_i;
        prev_ok_q <= 1'b1;
      end else if (slip_i) begin
        prev_ok_q <= 1'b0;
      end
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/esf_crc6_unit.sv
module esf_crc6_unit
  import esf_crc6_pkg::*;
#(
  parameter int FRAME_BITS = 193,
  parameter int FRAMES     = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             j1_mode_i,
  input  logic             force_err_i,
  input  logic             tx_bit_en_i,
  input  logic             tx_mf_start_i,
  input  logic             tx_data_i,
  output logic [CRC_W-1:0] tx_crc_o,
  input  logic             rx_bit_en_i,
  input  logic             rx_mf_start_i,
  input  logic             rx_data_i,
  output logic             rx_err_o
);
  localparam int FRM_W = $clog2(FRAMES);
  localparam int IDX_W = FRM_W - 2;

  slot_e            tx_slot, rx_slot;
  logic [IDX_W-1:0] tx_idx, rx_idx;
  logic             tx_first, tx_last, tx_slip;
  logic             rx_first, rx_last, rx_slip;
  logic             tx_end_w, rx_end_w;
  logic [CRC_W-1:0] tx_calc, rx_calc, tx_crc_q;

  esf_pos_tracker #(.FRAME_BITS(FRAME_BITS), .FRAMES(FRAMES)) u_tx_pos (
    .clk_i, .rst_ni, .bit_en_i(tx_bit_en_i), .mf_start_i(tx_mf_start_i),
    .slot_o(tx_slot), .crc_idx_o(tx_idx), .first_o(tx_first), .last_o(tx_last), .slip_o(tx_slip)
  );

  esf_crc6_engine u_tx_crc (
    .clk_i, .rst_ni, .bit_en_i(tx_bit_en_i), .first_i(tx_first), .last_i(tx_last),
    .slot_i(tx_slot), .data_i(tx_data_i), .j1_mode_i, .done_o(tx_end_w), .crc_o(tx_calc)
  );

  esf_pos_tracker #(.FRAME_BITS(FRAME_BITS), .FRAMES(FRAMES)) u_rx_pos (
    .clk_i, .rst_ni, .bit_en_i(rx_bit_en_i), .mf_start_i(rx_mf_start_i),
    .slot_o(rx_slot), .crc_idx_o(rx_idx), .first_o(rx_first), .last_o(rx_last), .slip_o(rx_slip)
  );

  esf_crc6_engine u_rx_crc (
    .clk_i, .rst_ni, .bit_en_i(rx_bit_en_i), .first_i(rx_first), .last_i(rx_last),
    .slot_i(rx_slot), .data_i(rx_data_i), .j1_mode_i, .done_o(rx_end_w), .crc_o(rx_calc)
  );

  esf_crc_rx_cmp #(.IDX_W(IDX_W)) u_rx_cmp (
    .clk_i, .rst_ni, .bit_en_i(rx_bit_en_i), .slot_i(rx_slot), .crc_idx_i(rx_idx),
    .data_i(rx_data_i), .slip_i(rx_slip), .done_i(rx_end_w), .calc_i(rx_calc), .err_o(rx_err_o)
  );

  // force is sampled once per multiframe so the inserted word is consistent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tx_crc_q <= '0;
    else if (tx_end_w) tx_crc_q <= tx_calc ^ {CRC_W{force_err_i}};
  end

  assign tx_crc_o = tx_crc_q;
endmodule

// File: rtl/esf_crc6_chk.sv
module esf_crc6_chk
  import esf_crc6_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_bit_en_i,
  input logic             rx_bit_en_i,
  input logic [CRC_W-1:0] tx_crc_o,
  input logic             rx_err_o,
  input logic             tx_end_w,
  input logic             rx_end_w
);
  // R1
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_end_w |=> $stable(tx_crc_o));

  // R8
  tx_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_bit_en_i |=> $stable(tx_crc_o));

  // R6
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_err_o |=> !rx_err_o);

  // R6
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_err_o |-> $past(rx_end_w));

  // R8
  rx_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_bit_en_i |=> !rx_err_o);
endmodule

bind esf_crc6_unit esf_crc6_chk u_chk (.*);

// File: tb/esf_crc6_unit_test.sv
module esf_crc6_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       j1 = 1'b0, frc = 1'b0;
  logic       bit_en = 1'b0, mf_start = 1'b0, din = 1'b0;
  logic [5:0] tx_crc;
  logic       rx_err;

  int         n_checks = 0, n_fail = 0, err_seen = 0, mf_n = 0;
  logic [5:0] prev_model = '0, last_tx = '0;
  bit         prev_ok = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  esf_crc6_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .j1_mode_i(j1), .force_err_i(frc),
    .tx_bit_en_i(bit_en), .tx_mf_start_i(mf_start), .tx_data_i(din), .tx_crc_o(tx_crc),
    .rx_bit_en_i(bit_en), .rx_mf_start_i(mf_start), .rx_data_i(din), .rx_err_o(rx_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // one bit, sometimes preceded by an idle cycle carrying stray start/data (R8)
  task automatic drive_bit(input logic d, input logic ms);
    if (($urandom % 11) == 0) begin
      @(negedge clk);
      if (rx_err) err_seen++;
      bit_en = 1'b0; mf_start = 1'b1; din = 1'($urandom);
    end
    @(negedge clk);
    if (rx_err) err_seen++;
    bit_en = 1'b1; mf_start = ms; din = d;
  endtask

  // remainder of M(x)*x^6 by long division on a 7-bit window
  function automatic logic [6:0] div_step(input logic [6:0] r, input logic b);
    logic [6:0] t;
    t = {r[5:0], b};
    if (t[6]) t = t ^ 7'h43;
    return t;
  endfunction

  task automatic run_mf(input bit mode, input bit force_on, input logic [5:0] bad, input int cut);
    logic [6:0] rem;
    logic [5:0] ins, model, exp_tx;
    logic       d, m;
    bit         exp_err;
    int         idx;
    string      lbl;
    j1 = mode; frc = force_on; err_seen = 0; rem = '0; idx = 0;
    ins = prev_model ^ bad;
    for (int f = 0; f < 24; f++) begin
      for (int b = 0; b < 193; b++) begin
        if (cut == 0 || idx < cut) begin
          if (b != 0) begin
            d = 1'($urandom); m = d;
          end else if (f % 2 == 0) begin
            d = 1'($urandom); m = 1'b1;            // data link
          end else if (f % 4 == 1) begin
            d = ins[5 - f/4]; m = 1'b1;            // check slot, frame 2 = MSB (R5)
          end else begin
            d = 1'($urandom); m = mode ? d : 1'b1; // pattern slot (R2/R3)
          end
          drive_bit(d, (f == 0 && b == 0));
          rem = div_step(rem, m);
          idx++;
        end
      end
    end
    @(negedge clk);
    if (rx_err) err_seen++;
    bit_en = 1'b0; mf_start = 1'b0;
    if (cut == 0) begin
      for (int z = 0; z < 6; z++) rem = div_step(rem, 1'b0);
      model  = rem[5:0];
      exp_tx = model ^ {6{force_on}};
      lbl = force_on ? "R4" : (mode ? "R3" : "R2");
      // R1 value at the cycle after the last bit
      chk(tx_crc == exp_tx, lbl, tx_crc, exp_tx);
      exp_err = prev_ok && (ins != prev_model);
      lbl = !prev_ok ? "R7" : ((bad != 0) ? "R6" : "R5");
      chk(rx_err == exp_err, lbl, rx_err, exp_err);
      chk(err_seen == int'(exp_err), "R6", err_seen, int'(exp_err));
      prev_model = model; prev_ok = 1'b1; last_tx = exp_tx;
    end else begin
      chk(tx_crc == last_tx, "R7", tx_crc, last_tx);
      chk(err_seen == 0, "R7", err_seen, 0);
      prev_ok = 1'b0;
    end
    mf_n++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9
    chk(tx_crc == 6'd0, "R9", tx_crc, 0);
    chk(rx_err == 1'b0, "R9", rx_err, 0);
    rst_n = 1'b1;
    // R7: no update before the first start marker
    err_seen = 0;
    for (int i = 0; i < 5000; i++) drive_bit(1'($urandom), 1'b0);
    @(negedge clk);
    if (rx_err) err_seen++;
    bit_en = 1'b0;
    chk(tx_crc == 6'd0, "R7", tx_crc, 0);
    chk(err_seen == 0, "R7", err_seen, 0);
    // sweep mode x force x corrupt, corrupted slot rotating
    for (int md = 0; md < 2; md++)
      for (int fo = 0; fo < 2; fo++)
        for (int cr = 0; cr < 2; cr++)
          run_mf(md[0], fo[0], cr[0] ? (6'd1 << (mf_n % 6)) : 6'd0, 0);
    // realignment: partial multiframe, then restart mid-way
    run_mf(1'b0, 1'b0, 6'd0, 1500);
    run_mf(1'b0, 1'b0, 6'b100000, 0);  // R7: first after slip, no compare
    run_mf(1'b1, 1'b0, 6'd0, 0);
    run_mf(1'b1, 1'b1, 6'b000001, 0);
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end
endmodule